// File: doc/BRIEF.md
# Low-Power Sleep Mode Controller

This block picks the low-power state a processor core drops into when it executes its sleep instruction. It also drives the clock-enable lines for four peripheral groups: the interval timers, the serial port, the performance counters and the DMA engine. Two standby-control bits, sampled when the sleep strobe arrives, select one of three sleep depths. Each depth stops a different set of peripherals.

An interrupt that arrives while the core sleeps brings the state back to running, and every gated peripheral comes back with it. A synchronous reset does the same from any state. The clock-gating cells themselves and the interrupt arbitration sit outside this block. It only sees a single wake line that is already qualified.

Top module: `lp_power_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is RUNNING (code 0) and all four enables are 1.
- R2: A sleep strobe in RUNNING with `stby_sel` = 1 gives state STANDBY (code 3) after the next clock edge, whatever `deep_sel` is.
- R3: A sleep strobe in RUNNING with `stby_sel` = 0 and `deep_sel` = 1 gives state DEEP_SLEEP (code 2) after the next clock edge.
- R4: A sleep strobe in RUNNING with both select bits 0 gives state SLEEP (code 1) after the next clock edge.
- R5: In RUNNING and in SLEEP, all four enables are 1.
- R6: In DEEP_SLEEP, `en_dma` is 0 and the timer, serial and performance-counter enables are 1.
- R7: In STANDBY, the timer, serial and performance-counter enables are 0 and `en_dma` is 1.
- R8: With `wake` high at a clock edge in SLEEP, DEEP_SLEEP or STANDBY, the state is RUNNING after that edge and all enables are 1.
- R9: A sleep strobe outside RUNNING is ignored. The state and enables hold, whatever the select bits are.
- R10: With neither strobe nor wake asserted, the state holds across clock edges.
- R11: `wake` in RUNNING has no effect. When `sleep_req` and `wake` are both high in RUNNING, the sleep entry is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | One-cycle strobe from the sleep instruction |
| stby_sel | input | 1 | Standby select bit from the first standby-control register |
| deep_sel | input | 1 | Deep-sleep select bit from the second standby-control register |
| wake | input | 1 | Qualified pending-interrupt wake request |
| state_o | output | 2 | Power state: 0 RUNNING, 1 SLEEP, 2 DEEP_SLEEP, 3 STANDBY |
| en_tmr | output | 1 | Timer group clock enable |
| en_ser | output | 1 | Serial group clock enable |
| en_perf | output | 1 | Performance-counter group clock enable |
| en_dma | output | 1 | DMA group clock enable |

## Verification
The power state is one register, and the enables are decoded straight from it. A wrong state therefore appears on `state_o` and the enables on the cycle right after the edge that loaded it. Every sleep depth is entered from RUNNING and then left through wake. Each visit probes ignored strobes and idle hold, so a stuck, mis-prioritised or leaking transition shows up within one or two cycles of the stimulus. Entering sleep while wake is also high, and waking while already running, check that the two causes are kept apart.

// File: rtl/lp_pkg.sv
package lp_pkg;

    localparam int LP_STATE_W = 2;

    typedef enum logic [LP_STATE_W-1:0] {
        LP_RUN   = 2'd0,
        LP_SLEEP = 2'd1,
        LP_DEEP  = 2'd2,
        LP_STBY  = 2'd3
    } lp_state_e;

    typedef struct packed {
        logic tmr;
        logic ser;
        logic perf;
        logic dma;
    } lp_en_s;

    localparam lp_en_s LP_ALL_ON = '{tmr: 1'b1, ser: 1'b1, perf: 1'b1, dma: 1'b1};

    // Sleep depth chosen from the two select bits; standby has priority.
    function automatic lp_state_e lp_pick_depth(input logic stby, input logic deep);
        if (stby)      return LP_STBY;
        else if (deep) return LP_DEEP;
        else           return LP_SLEEP;
    endfunction

endpackage

// File: rtl/lp_depth_sel.sv
module lp_depth_sel
    import lp_pkg::*;
(
    input  logic      stby_sel,
    input  logic      deep_sel,
    output lp_state_e depth
);
    always_comb depth = lp_pick_depth(stby_sel, deep_sel);
endmodule

// File: rtl/lp_next_state.sv
module lp_next_state
    import lp_pkg::*;
(
    input  lp_state_e cur,
    input  logic      sleep_req,
    input  logic      wake,
    input  lp_state_e depth,
    output lp_state_e nxt
);
    always_comb begin
        nxt = cur;
        if (cur == LP_RUN) begin
            if (sleep_req) nxt = depth;
        end else if (wake) begin
            nxt = LP_RUN;
        end
    end
endmodule

// File: rtl/lp_gate_decode.sv
module lp_gate_decode
    import lp_pkg::*;
(
    input  lp_state_e state,
    output lp_en_s    en
);
    always_comb begin
        en = LP_ALL_ON;
        unique case (state)
            LP_DEEP: en.dma = 1'b0;
            LP_STBY: begin
                en.tmr  = 1'b0;
                en.ser  = 1'b0;
                en.perf = 1'b0;
            end
            default: en = LP_ALL_ON;
        endcase
    end
endmodule

// File: rtl/lp_power_ctrl.sv
module lp_power_ctrl
    import lp_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sleep_req,
    input  logic                  stby_sel,
    input  logic                  deep_sel,
    input  logic                  wake,
    output logic [LP_STATE_W-1:0] state_o,
    output logic                  en_tmr,
    output logic                  en_ser,
    output logic                  en_perf,
    output logic                  en_dma
);
    lp_state_e state_q;
    lp_state_e state_d;
    lp_state_e depth;
    lp_en_s    en;

    lp_depth_sel u_depth (
        .stby_sel (stby_sel),
        .deep_sel (deep_sel),
        .depth    (depth)
    );

    lp_next_state u_next (
        .cur       (state_q),
        .sleep_req (sleep_req),
        .wake      (wake),
        .depth     (depth),
        .nxt       (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= LP_RUN;
        else     state_q <= state_d;
    end

    lp_gate_decode u_gate (
        .state (state_q),
        .en    (en)
    );

    assign state_o = state_q;
    assign en_tmr  = en.tmr;
    assign en_ser  = en.ser;
    assign en_perf = en.perf;
    assign en_dma  = en.dma;
endmodule

// File: rtl/lp_ctrl_chk.sv
module lp_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       sleep_req,
    input logic       stby_sel,
    input logic       deep_sel,
    input logic       wake,
    input logic [1:0] state_o,
    input logic       en_tmr,
    input logic       en_ser,
    input logic       en_perf,
    input logic       en_dma
);
    a_r2_standby: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd0 && sleep_req && stby_sel) |=> (state_o == 2'd3));
    a_r3_deep: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd0 && sleep_req && !stby_sel && deep_sel) |=> (state_o == 2'd2));
    a_r4_sleep: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd0 && sleep_req && !stby_sel && !deep_sel) |=> (state_o == 2'd1));
    a_r5_all_on: assert property (@(posedge clk) disable iff (rst)
        (state_o <= 2'd1) |-> (en_tmr && en_ser && en_perf && en_dma));
    a_r6_deep_gate: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd2) |-> (!en_dma && en_tmr && en_ser && en_perf));
    a_r7_stby_gate: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd3) |-> (en_dma && !en_tmr && !en_ser && !en_perf));
    a_r8_wake: assert property (@(posedge clk) disable iff (rst)
        (state_o != 2'd0 && wake) |=> (state_o == 2'd0));
    a_r9_ignore: assert property (@(posedge clk) disable iff (rst)
        (state_o != 2'd0 && !wake) |=> $stable(state_o));
    a_r11_run_wake: assert property (@(posedge clk) disable iff (rst)
        (state_o == 2'd0 && !sleep_req) |=> (state_o == 2'd0));
endmodule

bind lp_power_ctrl lp_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sleep_req (sleep_req),
    .stby_sel  (stby_sel),
    .deep_sel  (deep_sel),
    .wake      (wake),
    .state_o   (state_o),
    .en_tmr    (en_tmr),
    .en_ser    (en_ser),
    .en_perf   (en_perf),
    .en_dma    (en_dma)
);

// File: tb/tb_lp_power_ctrl.sv
module tb_lp_power_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sleep_req = 1'b0;
    logic       stby_sel = 1'b0;
    logic       deep_sel = 1'b0;
    logic       wake = 1'b0;
    logic [1:0] state_o;
    logic       en_tmr, en_ser, en_perf, en_dma;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    lp_power_ctrl dut (
        .clk(clk), .rst(rst), .sleep_req(sleep_req), .stby_sel(stby_sel),
        .deep_sel(deep_sel), .wake(wake), .state_o(state_o),
        .en_tmr(en_tmr), .en_ser(en_ser), .en_perf(en_perf), .en_dma(en_dma)
    );

    // Vector layout: {stby_sel, deep_sel, expected state, expected enables tmr,ser,perf,dma}
    localparam int NV = 4;
    localparam logic [7:0] VEC [NV] = '{
        {1'b0, 1'b0, 2'd1, 4'b1111},
        {1'b0, 1'b1, 2'd2, 4'b1110},
        {1'b1, 1'b0, 2'd3, 4'b0001},
        {1'b1, 1'b1, 2'd3, 4'b0001}
    };

    task automatic check(input string req, input logic [1:0] exp_s, input logic [3:0] exp_en);
        logic [3:0] act_en;
        act_en = {en_tmr, en_ser, en_perf, en_dma};
        n_chk++;
        if (state_o !== exp_s || act_en !== exp_en) begin
            n_fail++;
            $display("FAIL %s: state=%0d en=%b expected state=%0d en=%b",
                     req, state_o, act_en, exp_s, exp_en);
        end
    endtask

    // Apply inputs after a falling edge, let one rising edge pass, sample at the next falling edge.
    task automatic step(input logic s, input logic a, input logic b, input logic w);
        @(negedge clk);
        sleep_req = s; stby_sel = a; deep_sel = b; wake = w;
        @(negedge clk);
        sleep_req = 1'b0; wake = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R1 reset", 2'd0, 4'b1111);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [1:0] es;
            logic [3:0] ee;
            es = VEC[i][5:4];
            ee = VEC[i][3:0];
            step(1'b1, VEC[i][7], VEC[i][6], 1'b0);
            check(es == 2'd3 ? "R2 standby" : (es == 2'd2 ? "R3 deep" : "R4 sleep"), es, ee);
            check(es == 2'd3 ? "R7 standby gates" : (es == 2'd2 ? "R6 deep gates" : "R5 sleep gates"), es, ee);
            step(1'b1, ~VEC[i][7], ~VEC[i][6], 1'b0);
            check("R9 strobe ignored while asleep", es, ee);
            step(1'b0, 1'b0, 1'b0, 1'b0);
            check("R10 hold", es, ee);
            step(1'b0, 1'b0, 1'b0, 1'b1);
            check("R8 wake", 2'd0, 4'b1111);
        end

        step(1'b0, 1'b1, 1'b1, 1'b1);
        check("R11 wake in running", 2'd0, 4'b1111);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        check("R5 running enables", 2'd0, 4'b1111);
        step(1'b1, 1'b0, 1'b1, 1'b1);
        check("R11 sleep wins over wake", 2'd2, 4'b1110);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        check("R8 wake from deep", 2'd0, 4'b1111);

        step(1'b1, 1'b1, 1'b0, 1'b0);
        check("R2 standby again", 2'd3, 4'b0001);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 reset from standby", 2'd0, 4'b1111);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule